// File: doc/BRIEF.md
# Serial SLIP Frame Receiver

This block takes an asynchronous 8N1 serial line, rebuilds bytes from it and strips the SLIP framing. The decoded payload goes out one byte per strobe, together with a frame-start marker and a frame-end marker. A downstream serial-link transmitter uses these markers to open and close its bursts. Each SLIP frame on the wire becomes exactly one downstream burst. Payload bytes pass through unchanged, because any checksum or error-correction code in them was computed before the bytes reached the line.

The bit period is set by a clock-divider parameter. The default suits a 125 MHz clock and a line near 2.77 Mbaud. Line errors are reported as single-cycle flags: a low stop bit, or an escape byte followed by an illegal code. They are never passed downstream as data.

Top module: `slip_uart_rx`

## Requirements
- R1: While reset is high, and on the first cycle after it, every output is 0.
- R2: A line byte sent 8N1, LSB first, with its start bit beginning on a falling edge and each bit lasting CLKS_PER_BIT clocks, is delivered unchanged on `pay_data_o`. When the byte is not one of the special codes in R3 and R4, `pay_valid_o` is high for one cycle to mark it.
- R3: Code 0xC0 is the frame delimiter. The first payload byte after it is delivered with `burst_open_o` high in the same cycle. A 0xC0 that closes a frame holding at least one payload byte raises `burst_close_o` for one cycle, with `pay_valid_o` low in that cycle.
- R4: Code 0xDB followed by 0xDC delivers payload 0xC0. Code 0xDB followed by 0xDD delivers payload 0xDB.
- R5: Two or more 0xC0 codes with no payload byte between them produce no payload byte and no open or close strobe.
- R6: 0xDB followed by any code other than 0xDC or 0xDD, including 0xC0, raises `esc_err_o` for one cycle. Every byte after the error is dropped up to the next 0xC0. If the frame had already opened, that 0xC0 still raises `burst_close_o`.
- R7: A stop bit sampled low raises `stop_err_o` for one cycle. That byte is dropped, and the bytes around it are not affected.
- R8: A low pulse on the line that is shorter than half a bit period is treated as noise. It produces no byte and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| pay_data_o | output | 8 | Decoded payload byte |
| pay_valid_o | output | 1 | Payload byte strobe |
| burst_open_o | output | 1 | Frame start, coincides with its first payload byte |
| burst_close_o | output | 1 | Frame end strobe |
| stop_err_o | output | 1 | Low stop bit seen, byte dropped |
| esc_err_o | output | 1 | Illegal escape sequence seen |

## Verification
One frame carries all 256 byte values, escaped as needed. This separates bit order and sampling faults from decoder faults, and it shows that both escape substitutions work for the codes that need them. Short patterns then separate the framing decisions from one another:
- runs of back-to-back delimiters;
- an illegal escape inside a frame, before any payload, and just ahead of a delimiter;
- a byte with a low stop bit between two good bytes;
- a sub-half-bit glitch inside a frame.

Together these show whether the strobes come from payload presence or from delimiter counting.

// File: rtl/slip_pkg.sv
package slip_pkg;
  localparam logic [7:0] SLIP_DELIM   = 8'hC0;
  localparam logic [7:0] SLIP_ESC     = 8'hDB;
  localparam logic [7:0] SLIP_ESC_END = 8'hDC;
  localparam logic [7:0] SLIP_ESC_ESC = 8'hDD;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_t;
endpackage

// File: rtl/uart_bit_rx.sv
module uart_bit_rx
  import slip_pkg::*;
#(
  parameter int CLKS_PER_BIT = 45,
  parameter int DATA_BITS    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rxd_i,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 byte_valid_o,
  output logic                 stop_err_o
);
  localparam int CW   = $clog2(CLKS_PER_BIT);
  localparam int HALF = CLKS_PER_BIT / 2;
  localparam int BW   = $clog2(DATA_BITS);

  logic [1:0]           sync_q;
  logic                 rx_s, rx_prev;
  rx_state_t            state;
  logic [CW-1:0]        cnt;
  logic [BW-1:0]        bit_idx;
  logic [DATA_BITS-1:0] shift_q;

  assign rx_s = sync_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= 2'b11;
      rx_prev <= 1'b1;
    end else begin
      sync_q  <= {sync_q[0], rxd_i};
      rx_prev <= rx_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= RX_IDLE;
      cnt          <= '0;
      bit_idx      <= '0;
      shift_q      <= '0;
      byte_o       <= '0;
      byte_valid_o <= 1'b0;
      stop_err_o   <= 1'b0;
    end else begin
      byte_valid_o <= 1'b0;
      stop_err_o   <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (rx_prev && !rx_s) begin
            cnt   <= CW'(HALF - 1);
            state <= RX_START;
          end
        end
        RX_START: begin
          if (cnt == '0) begin
            if (!rx_s) begin
              cnt     <= CW'(CLKS_PER_BIT - 1);
              bit_idx <= '0;
              state   <= RX_DATA;
            end else begin
              state <= RX_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt == '0) begin
            shift_q <= {rx_s, shift_q[DATA_BITS-1:1]};
            cnt     <= CW'(CLKS_PER_BIT - 1);
            if (bit_idx == BW'(DATA_BITS - 1)) state <= RX_STOP;
            else bit_idx <= bit_idx + 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) begin
            if (rx_s) begin
              byte_o       <= shift_q;
              byte_valid_o <= 1'b1;
            end else begin
              stop_err_o <= 1'b1;
            end
            state <= RX_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  // R8: data phase is entered only after the start bit was confirmed low
  a_r8_start_confirmed: assert property (@(posedge clk) disable iff (rst)
    (state == RX_DATA && $past(state) == RX_START) |-> $past(!rx_s));

  // R2: a received byte is a single-cycle strobe
  a_r2_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    byte_valid_o |=> !byte_valid_o);

  // R7: a stop error is a single-cycle flag
  a_r7_err_pulse: assert property (@(posedge clk) disable iff (rst)
    stop_err_o |=> !stop_err_o);
endmodule

// File: rtl/slip_unframe.sv
module slip_unframe
  import slip_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] byte_i,
  input  logic       byte_valid_i,
  output logic [7:0] pay_data_o,
  output logic       pay_valid_o,
  output logic       burst_open_o,
  output logic       burst_close_o,
  output logic       esc_err_o
);
  logic started_q, esc_q, discard_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      started_q     <= 1'b0;
      esc_q         <= 1'b0;
      discard_q     <= 1'b0;
      pay_data_o    <= '0;
      pay_valid_o   <= 1'b0;
      burst_open_o  <= 1'b0;
      burst_close_o <= 1'b0;
      esc_err_o     <= 1'b0;
    end else begin
      pay_valid_o   <= 1'b0;
      burst_open_o  <= 1'b0;
      burst_close_o <= 1'b0;
      esc_err_o     <= 1'b0;
      if (byte_valid_i) begin
        if (byte_i == SLIP_DELIM) begin
          burst_close_o <= started_q;
          esc_err_o     <= esc_q;
          started_q     <= 1'b0;
          esc_q         <= 1'b0;
          discard_q     <= 1'b0;
        end else if (discard_q) begin
          esc_q <= 1'b0;
        end else if (esc_q) begin
          esc_q <= 1'b0;
          if (byte_i == SLIP_ESC_END || byte_i == SLIP_ESC_ESC) begin
            pay_data_o   <= (byte_i == SLIP_ESC_END) ? SLIP_DELIM : SLIP_ESC;
            pay_valid_o  <= 1'b1;
            burst_open_o <= !started_q;
            started_q    <= 1'b1;
          end else begin
            esc_err_o <= 1'b1;
            discard_q <= 1'b1;
          end
        end else if (byte_i == SLIP_ESC) begin
          esc_q <= 1'b1;
        end else begin
          pay_data_o   <= byte_i;
          pay_valid_o  <= 1'b1;
          burst_open_o <= !started_q;
          started_q    <= 1'b1;
        end
      end
    end
  end

  a_r3_open_has_data: assert property (@(posedge clk) disable iff (rst)
    burst_open_o |-> pay_valid_o);

  a_r3_close_alone: assert property (@(posedge clk) disable iff (rst)
    burst_close_o |-> !pay_valid_o);

  a_r5_close_needs_frame: assert property (@(posedge clk) disable iff (rst)
    burst_close_o |-> $past(started_q));

  a_r6_discard_silent: assert property (@(posedge clk) disable iff (rst)
    pay_valid_o |-> $past(!discard_q));
endmodule

// File: rtl/slip_uart_rx.sv
module slip_uart_rx
  import slip_pkg::*;
#(
  parameter int CLKS_PER_BIT = 45
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxd_i,
  output logic [7:0] pay_data_o,
  output logic       pay_valid_o,
  output logic       burst_open_o,
  output logic       burst_close_o,
  output logic       stop_err_o,
  output logic       esc_err_o
);
  logic [7:0] line_byte;
  logic       line_valid;

  uart_bit_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(8)) u_rx (
    .clk          (clk),
    .rst          (rst),
    .rxd_i        (rxd_i),
    .byte_o       (line_byte),
    .byte_valid_o (line_valid),
    .stop_err_o   (stop_err_o)
  );

  slip_unframe u_unframe (
    .clk           (clk),
    .rst           (rst),
    .byte_i        (line_byte),
    .byte_valid_i  (line_valid),
    .pay_data_o    (pay_data_o),
    .pay_valid_o   (pay_valid_o),
    .burst_open_o  (burst_open_o),
    .burst_close_o (burst_close_o),
    .esc_err_o     (esc_err_o)
  );
endmodule

// File: tb/tb_slip_uart_rx.sv
module tb_slip_uart_rx;
  localparam int CPB = 8;

  logic clk = 1'b0, rst = 1'b1, rxd = 1'b1;
  logic [7:0] pay_data;
  logic pay_valid, burst_open, burst_close, stop_err, esc_err;

  always #4 clk = ~clk;

  slip_uart_rx #(.CLKS_PER_BIT(CPB)) dut (
    .clk(clk), .rst(rst), .rxd_i(rxd),
    .pay_data_o(pay_data), .pay_valid_o(pay_valid),
    .burst_open_o(burst_open), .burst_close_o(burst_close),
    .stop_err_o(stop_err), .esc_err_o(esc_err)
  );

  int n_tests = 0, n_fail = 0;
  int got_esc = 0, got_stop = 0, exp_esc = 0, exp_stop = 0;
  logic [9:0] got_q[$];
  logic [9:0] exp_q[$];

  // event code: bit9 = open with data, bit8 = close, [7:0] data
  always @(negedge clk) begin
    if (!rst) begin
      if (pay_valid) got_q.push_back({burst_open, 1'b0, pay_data});
      if (burst_close) got_q.push_back(10'h100);
      if (esc_err) got_esc++;
      if (stop_err) got_stop++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic line_byte(input logic [7:0] b, input bit stop_ok = 1'b1);
    @(negedge clk) rxd = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (CPB) @(negedge clk);
    end
    rxd = stop_ok;
    repeat (CPB) @(negedge clk);
    rxd = 1'b1;
    repeat (CPB) @(negedge clk);
  endtask

  task automatic enc_byte(input logic [7:0] b);
    if (b == 8'hC0) begin line_byte(8'hDB); line_byte(8'hDC); end
    else if (b == 8'hDB) begin line_byte(8'hDB); line_byte(8'hDD); end
    else line_byte(b);
  endtask

  task automatic expect_data(input logic [7:0] b, input bit first);
    exp_q.push_back({first, 1'b0, b});
  endtask

  task automatic expect_close();
    exp_q.push_back(10'h100);
  endtask

  task automatic settle_and_compare(input string req);
    repeat (3 * CPB) @(negedge clk);
    check(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
    check(got_esc == exp_esc, {req, " esc_err count"}, got_esc, exp_esc);
    check(got_stop == exp_stop, {req, " stop_err count"}, got_stop, exp_stop);
    got_q.delete(); exp_q.delete();
    got_esc = 0; got_stop = 0; exp_esc = 0; exp_stop = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    check({pay_data, pay_valid, burst_open, burst_close, stop_err, esc_err} == '0,
          "R1 outputs during reset", {pay_valid, burst_open, burst_close}, 0);
    rst = 1'b0;
    @(negedge clk);
    check({pay_data, pay_valid, burst_open, burst_close, stop_err, esc_err} == '0,
          "R1 outputs after reset", {pay_valid, burst_open, burst_close}, 0);
    repeat (2 * CPB) @(negedge clk);

    // R2 R3 R4: every byte value in one frame, escaped where needed
    line_byte(8'hC0);
    for (int v = 0; v < 256; v++) begin
      enc_byte(8'(v));
      expect_data(8'(v), v == 0);
    end
    line_byte(8'hC0);
    expect_close();
    settle_and_compare("R2/R3/R4 full byte sweep");

    // R4: frame opening with escaped codes
    line_byte(8'hC0);
    enc_byte(8'hDB); expect_data(8'hDB, 1'b1);
    enc_byte(8'hC0); expect_data(8'hC0, 1'b0);
    line_byte(8'hC0); expect_close();
    settle_and_compare("R4 escaped codes at frame start");

    // R5: back-to-back delimiters
    line_byte(8'hC0); line_byte(8'hC0); line_byte(8'hC0);
    settle_and_compare("R5 empty frames");
    line_byte(8'h3C); expect_data(8'h3C, 1'b1);
    line_byte(8'hC0); expect_close();
    line_byte(8'hC0);
    settle_and_compare("R5 delimiter run after frame");

    // R6: illegal escape inside an open frame
    line_byte(8'hC0);
    line_byte(8'h11); expect_data(8'h11, 1'b1);
    line_byte(8'hDB); line_byte(8'h55); exp_esc++;
    line_byte(8'h22); line_byte(8'hDB); line_byte(8'hDC);
    line_byte(8'hC0); expect_close();
    settle_and_compare("R6 illegal escape in frame");

    // R6: illegal escape before any payload
    line_byte(8'hDB); line_byte(8'h33); exp_esc++;
    line_byte(8'h44);
    line_byte(8'hC0);
    settle_and_compare("R6 illegal escape before payload");

    // R6: escape followed by delimiter
    line_byte(8'h66); expect_data(8'h66, 1'b1);
    line_byte(8'hDB); line_byte(8'hC0); exp_esc++; expect_close();
    line_byte(8'h67); expect_data(8'h67, 1'b1);
    line_byte(8'hC0); expect_close();
    settle_and_compare("R6 escape then delimiter");

    // R7: low stop bit drops only that byte
    line_byte(8'h5A); expect_data(8'h5A, 1'b1);
    line_byte(8'h77, 1'b0); exp_stop++;
    line_byte(8'h88); expect_data(8'h88, 1'b0);
    line_byte(8'hC0); expect_close();
    settle_and_compare("R7 stop bit low");

    // R8: short glitch inside a frame
    line_byte(8'hA5); expect_data(8'hA5, 1'b1);
    @(negedge clk) rxd = 1'b0;
    repeat (2) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * CPB) @(negedge clk);
    line_byte(8'h96); expect_data(8'h96, 1'b0);
    line_byte(8'hC0); expect_close();
    settle_and_compare("R8 glitch rejected");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule